// File: doc/BRIEF.md
# System Control Port Register

This block is a single byte-wide control register that a host reaches through one I/O address on a simple parallel bus. The bus has an address, write data, read data, a read strobe and a write strobe. The register holds a byte that software writes in full and can read back in full. Bit 1 of the stored byte drives the gate output for address line 20. Bit 0 is a self-reset trigger: when a write moves it from 0 to 1, the block sends a one-clock reset request to the reset controller.

The block has two reset inputs. Power-on reset clears the whole byte. System reset clears only the trigger bit and leaves bits 7 to 1 alone. Because of this, the A20 setting and the other bits survive a reset that the register itself requested. Accesses to any other address are ignored. Reads have no side effects.

Top module: `sysctl_port`

## Requirements
- R1: While `rst_n` is low at a clock edge (power-on reset), the stored byte becomes 0x00. After that edge, `gate_a20` and `rst_req` are 0, and a read returns 0x00.
- R2: A write strobe with address 0x0092 replaces all 8 stored bits with `bus_wdata` at that clock edge. A later read at 0x0092 returns exactly that byte.
- R3: `gate_a20` equals bit 1 of the stored byte. It takes the new value from the clock edge that stores the write.
- R4: `rst_req` is high for exactly one cycle, the cycle after a write to 0x0092 whose data has bit 0 = 1 while the stored bit 0 was 0.
- R5: A write that puts 1 into bit 0 while the stored bit 0 is already 1 raises no `rst_req`. A write with bit 0 = 0 raises no `rst_req` either.
- R6: While `sys_rst_n` is low at a clock edge, stored bit 0 becomes 0 and bits 7 to 1 keep their values. A write in that same cycle is dropped and raises no `rst_req`. After this, a write with bit 0 = 1 raises a new request.
- R7: `bus_rdata` shows the stored byte only while `bus_rd` is high and the address is 0x0092; otherwise it is 0x00. Reading does not change the stored byte.
- R8: A write to any address other than 0x0092 changes neither the stored byte nor `gate_a20`, and raises no `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; clears all bits |
| sys_rst_n | input | 1 | System reset, synchronous, active low; clears bit 0 only |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, 0 unless this register is being read |
| gate_a20 | output | 1 | Address line 20 gate, bit 1 of the stored byte |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench checks the edge rule for bit 0 in several cases:
- Writing 1 over 1 must give no request. A design that decodes the level of bit 0 instead of its rising edge would raise a repeated request here.
- After a system reset, a fresh write must give a request again. A design that keeps bit 0 through system reset would stay silent.
- A write in the same cycle as a system reset must be dropped.

It also checks that a system reset keeps the A20 bit and the reserved bits. A design that cleared the whole byte would drop the A20 gate after a reset it caused itself.

It writes to addresses that differ from 0x0092 only in the upper byte or only in the lowest bit, which catches a partial address decode. It reads with the strobe low or at a wrong address, which catches read data that is not gated to zero.

// File: rtl/sysctl_port_pkg.sv
// Shared constants and types for the system control port register.
// Assumes a byte-wide data path; bit positions are fixed by the behaviour.
package sysctl_port_pkg;
    localparam int unsigned CTL_W    = 8;
    localparam int unsigned TRIG_BIT = 0;
    localparam int unsigned A20_BIT  = 1;

    typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
// Address decoder: qualifies the read and write strobes with a full compare
// of the bus address against the single port address.
// Assumes the strobes are valid for one cycle per access.
module sysctl_addr_dec #(
    parameter int unsigned     ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic match;

    // Full-width compare so aliases in the upper address bits are rejected.
    always_comb begin
        match  = (addr == PORT_ADDR);
        rd_hit = rd && match;
        wr_hit = wr && match;
    end
endmodule

// File: rtl/sysctl_ctl_reg.sv
// Control byte storage with two reset domains and rising-edge detection on
// the trigger bit. Power-on reset clears all bits. System reset clears only
// the trigger bit and blocks a write in the same cycle.
// Assumes both resets are synchronous and active low.
module sysctl_ctl_reg
    import sysctl_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst_n,
    input  logic wr_hit,
    input  ctl_t wdata,
    output ctl_t ctl_q,
    output logic trig_set
);
    ctl_t ctl_d;

    // Next-state selection: system reset first, then an accepted write.
    always_comb begin
        ctl_d = ctl_q;
        if (!sys_rst_n) begin
            ctl_d[TRIG_BIT] = 1'b0;
        end else if (wr_hit) begin
            ctl_d = wdata;
        end
    end

    // A 0-to-1 move of the trigger bit caused by an accepted write.
    always_comb begin
        trig_set = sys_rst_n && wr_hit && wdata[TRIG_BIT] && !ctl_q[TRIG_BIT];
    end

    // Storage register; power-on reset dominates everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/sysctl_req_pulse.sv
// Registers the trigger event into a reset request that lasts one clock.
// Assumes trig_set cannot be high on two back-to-back cycles, because the
// stored trigger bit is already 1 after the first event.
module sysctl_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_set,
    output logic req
);
    // Registered request, cleared by power-on reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= trig_set;
        end
    end
endmodule

// File: rtl/sysctl_port.sv
// System control port register, top level. One byte at one I/O address:
// bit 1 drives the address line 20 gate, and a rising write of bit 0 issues
// a one-cycle reset request. Read data is zero unless this port is read.
// Assumes single-byte accesses and synchronous active-low resets.
module sysctl_port
    import sysctl_port_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [CTL_W-1:0]  bus_rdata,
    output logic              gate_a20,
    output logic              rst_req
);
    logic rd_hit;
    logic wr_hit;
    logic trig_set;
    ctl_t ctl_q;

    sysctl_addr_dec #(
        .ADDR_W   (ADDR_W),
        .PORT_ADDR(PORT_ADDR)
    ) u_dec (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .rd_hit(rd_hit),
        .wr_hit(wr_hit)
    );

    sysctl_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst_n(sys_rst_n),
        .wr_hit   (wr_hit),
        .wdata    (bus_wdata),
        .ctl_q    (ctl_q),
        .trig_set (trig_set)
    );

    sysctl_req_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_set(trig_set),
        .req     (rst_req)
    );

    // Outputs: gated read data and the A20 gate taken from the stored byte.
    always_comb begin
        bus_rdata = rd_hit ? ctl_q : '0;
        gate_a20  = ctl_q[A20_BIT];
    end
endmodule

// File: rtl/sysctl_port_chk.sv
// Property checker for sysctl_port, attached with bind. Observes the ports
// and the stored byte; drives nothing.
module sysctl_port_chk
    import sysctl_port_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CTL_W-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [CTL_W-1:0]  bus_rdata,
    input logic              gate_a20,
    input logic              rst_req,
    input logic [CTL_W-1:0]  ctl_q
);
    logic hit_wr;
    logic hit_rd;

    // Independent decode of the port address from the bus pins.
    always_comb begin
        hit_wr = bus_wr && (bus_addr == PORT_ADDR);
        hit_rd = bus_rd && (bus_addr == PORT_ADDR);
    end

    // R1
    por_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0) && !rst_req);

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && sys_rst_n) |=> ctl_q == $past(bus_wdata));

    // R3
    a20_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && sys_rst_n) |=> gate_a20 == $past(bus_wdata[A20_BIT]));

    // R4
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && sys_rst_n && bus_wdata[TRIG_BIT] && !ctl_q[TRIG_BIT]) |=> rst_req);

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(ctl_q[TRIG_BIT]) && ctl_q[TRIG_BIT]);

    // R6
    sysrst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> ctl_q == {$past(ctl_q[CTL_W-1:1]), 1'b0});

    // R7
    rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_rd |-> bus_rdata == '0);

    // R8
    no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_wr && sys_rst_n) |=> $stable(ctl_q) && !rst_req);
endmodule

bind sysctl_port sysctl_port_chk #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
) u_sysctl_port_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst_n(sys_rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .gate_a20 (gate_a20),
    .rst_req  (rst_req),
    .ctl_q    (ctl_q)
);

// File: tb/test_sysctl_port.sv
// Self-checking bench for sysctl_port: a vector table walked by one loop,
// then directed tests for resets and corner cases.
module test_sysctl_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        gate_a20;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    sysctl_port i_sysctl_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst_n(sys_rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_rdata(bus_rdata),
        .gate_a20 (gate_a20),
        .rst_req  (rst_req)
    );

    // {address, write data, expected byte, expected a20, expected request}
    localparam int NV = 10;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {16'h0092, 8'h02, 8'h02, 1'b1, 1'b0},
        {16'h0092, 8'h03, 8'h03, 1'b1, 1'b1},
        {16'h0092, 8'h03, 8'h03, 1'b1, 1'b0},
        {16'h0092, 8'hA4, 8'hA4, 1'b0, 1'b0},
        {16'h0093, 8'hFF, 8'hA4, 1'b0, 1'b0},
        {16'h0192, 8'h01, 8'hA4, 1'b0, 1'b0},
        {16'h0092, 8'hFF, 8'hFF, 1'b1, 1'b1},
        {16'h0092, 8'h00, 8'h00, 1'b0, 1'b0},
        {16'h0092, 8'h55, 8'h55, 1'b0, 1'b1},
        {16'h0092, 8'hAA, 8'hAA, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the storing edge.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read in the current cycle.
    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: power-on state
        rst_n = 1'b1;
        @(negedge clk);
        do_read(16'h0092, rd);
        chk("R1 reset byte", rd, 8'h00);
        chk("R1 reset a20", {7'd0, gate_a20}, 8'h00);
        chk("R1 reset req", {7'd0, rst_req}, 8'h00);

        // Table: R2 store, R3 a20, R4/R5 request, R8 foreign addresses
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][33:18], VEC[i][17:10]);
            chk($sformatf("R4/R5 req vec%0d", i), {7'd0, rst_req}, {7'd0, VEC[i][0]});
            chk($sformatf("R3 a20 vec%0d", i), {7'd0, gate_a20}, {7'd0, VEC[i][1]});
            do_read(16'h0092, rd);
            chk($sformatf("R2/R8 byte vec%0d", i), rd, VEC[i][9:2]);
            @(negedge clk);
            chk($sformatf("R4 one-wide vec%0d", i), {7'd0, rst_req}, 8'h00);
        end

        // R7: read gating and no side effect
        do_read(16'h0093, rd);
        chk("R7 wrong addr read", rd, 8'h00);
        bus_addr = 16'h0092;
        #1 chk("R7 rd low", bus_rdata, 8'h00);
        do_read(16'h0092, rd);
        do_read(16'h0092, rd);
        chk("R7 repeat read", rd, 8'hAA);

        // R6: system reset keeps bits 7..1
        do_write(16'h0092, 8'h03);
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        do_read(16'h0092, rd);
        chk("R6 sysrst byte", rd, 8'h02);
        chk("R6 sysrst a20", {7'd0, gate_a20}, 8'h01);
        chk("R6 sysrst req", {7'd0, rst_req}, 8'h00);
        do_write(16'h0092, 8'h03);
        chk("R6 re-trigger req", {7'd0, rst_req}, 8'h01);
        @(negedge clk);

        // R6: write during system reset is dropped
        do_write(16'h0092, 8'h07);
        @(negedge clk);
        bus_addr = 16'h0092; bus_wdata = 8'hF8; bus_wr = 1'b1; sys_rst_n = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; sys_rst_n = 1'b1;
        chk("R6 dropped write req", {7'd0, rst_req}, 8'h00);
        do_read(16'h0092, rd);
        chk("R6 dropped write byte", rd, 8'h06);

        // R1: power-on reset mid-run clears everything
        do_write(16'h0092, 8'hFE);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read(16'h0092, rd);
        chk("R1 por byte", rd, 8'h00);
        chk("R1 por a20", {7'd0, gate_a20}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule